// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block gathers the interrupt conditions of a UART, picks the most urgent one that is enabled, and presents the result as an 8-bit read-only identification value. It also drives an interrupt request line. The conditions it takes are:

- a receiver line error;
- received data ready;
- a character time-out;
- an empty transmit holding register.

Level conditions are reported for as long as they stay asserted. The transmitter-empty condition is an event. It is latched when it arises and stays pending until the host either writes the transmit holding register or reads an identification value that reports it.

The host's read strobe stays high for the whole register access. During that time the identification value is frozen, even though new conditions keep being recorded underneath. Bits 7:6 show whether FIFO mode is on. The time-out source exists only in FIFO mode.

The asynchronous active-low reset is released through a short synchronizer.

Top module: `uart_int_ident`

## Requirements
- R1: After reset the identification value is 0x01 and irq_o is low.
- R2: Bit 0 is 0 when an interrupt is pending and 1 when none is pending. irq_o is always the inverse of bit 0.
- R3: Priority, from most to least urgent, and the code in bits 3:0 for each:
  - line error: 0110
  - character time-out: 1100
  - received data: 0100
  - transmitter empty: 0010
  - nothing pending: 0001
- R4: Time-out is reported only when fifo_en_i is 1. With fifo_en_i at 0 the time-out input is ignored and bit 3 is 0. Time-out is reported in place of received data when both are active.
- R5: Bits 7:6 read 11 when fifo_en_i is 1 and 00 otherwise. Bits 5:4 always read 0.
- R6: Each source is gated by its enable. Line error uses ie_line_i. Received data and time-out both use ie_rx_i. Transmitter empty uses ie_tx_i. A source whose enable is low does not affect the output.
- R7: While ident_rd_i is low, the output follows the conditions with one clock of latency. While ident_rd_i is high, the output and irq_o hold the value present when the read began.
- R8: Conditions that arise during a read are not lost. They appear in the first cycle after ident_rd_i falls.
- R9: A transmitter-empty event is a rising edge of (tx_empty_i AND ie_tx_i). It stays pending until it is cleared.
- R10: A read whose first cycle shows code 0010 clears the pending transmitter-empty event. A read that showed any other code leaves it pending.
- R11: A pulse on tx_write_i clears the pending transmitter-empty event, and the output shows the clear one cycle later. If a new event arrives in the same cycle as the pulse, the new event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | FIFO mode setting |
| line_err_i | input | 1 | Receiver line error condition |
| rx_ready_i | input | 1 | Received data ready condition |
| rx_timeout_i | input | 1 | Character time-out condition |
| tx_empty_i | input | 1 | Transmit holding register empty |
| tx_write_i | input | 1 | Write strobe of the transmit holding register |
| ie_line_i | input | 1 | Enable for the line error source |
| ie_rx_i | input | 1 | Enable for the received data and time-out sources |
| ie_tx_i | input | 1 | Enable for the transmitter-empty source |
| ident_rd_i | input | 1 | High for the whole access to the identification value |
| ident_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a transmitter-empty event that arrives partway through a read which began by reporting no interrupt. The event must survive the read, and it must not be cleared by that read. The bench reaches this case by holding ident_rd_i high for several cycles and raising tx_empty_i only after the first cycle of the read has passed.

A related case is a read that began while a line error was being shown. That read must leave a pending transmitter event intact. The bench builds it by stacking a line error on top of the event before the read, then dropping the line error.

An exhaustive sweep covers every combination of mode, level conditions, enables and transmitter state.

// File: rtl/uart_ii_pkg.sv
package uart_ii_pkg;
  localparam int NSRC = 4;
  localparam int CODE_W = 4;

  // Source index doubles as priority rank: lower index wins.
  localparam int SRC_LINE = 0;
  localparam int SRC_TOUT = 1;
  localparam int SRC_RXD  = 2;
  localparam int SRC_TXE  = 3;

  // Bits 3:0 of the identification value.
  localparam logic [CODE_W-1:0] CODE_LINE = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_TOUT = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_RXD  = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TXE  = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_LINE: src_code = CODE_LINE;
      SRC_TOUT: src_code = CODE_TOUT;
      SRC_RXD:  src_code = CODE_RXD;
      default:  src_code = CODE_TXE;
    endcase
  endfunction
endpackage

// File: rtl/uart_ii_srcq.sv
module uart_ii_srcq
  import uart_ii_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en_i,
  input  logic              line_err_i,
  input  logic              rx_ready_i,
  input  logic              rx_timeout_i,
  input  logic              tx_empty_i,
  input  logic              tx_write_i,
  input  logic              ie_line_i,
  input  logic              ie_rx_i,
  input  logic              ie_tx_i,
  input  logic              ident_rd_i,
  input  logic [CODE_W-1:0] shown_code_i,
  output logic [NSRC-1:0]   req_o
);
  logic tx_req, tx_req_q;
  logic tx_rise;
  logic tx_pend_d, tx_pend_q;
  logic rd_q, rd_start, rd_clr;

  always_comb begin
    tx_req   = tx_empty_i & ie_tx_i;
    tx_rise  = tx_req & ~tx_req_q;
    rd_start = ident_rd_i & ~rd_q;
    rd_clr   = rd_start & (shown_code_i == CODE_TXE);

    tx_pend_d = tx_pend_q;
    if (tx_write_i || rd_clr) tx_pend_d = 1'b0;
    if (tx_rise)              tx_pend_d = 1'b1;

    req_o           = '0;
    req_o[SRC_LINE] = line_err_i & ie_line_i;
    req_o[SRC_TOUT] = rx_timeout_i & ie_rx_i & fifo_en_i;
    req_o[SRC_RXD]  = rx_ready_i & ie_rx_i;
    req_o[SRC_TXE]  = ((tx_pend_q & ~tx_write_i) | tx_rise) & ie_tx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req_q  <= 1'b0;
      tx_pend_q <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      tx_req_q  <= tx_req;
      tx_pend_q <= tx_pend_d;
      rd_q      <= ident_rd_i;
    end
  end

  assert_rise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rise |=> tx_pend_q);

  assert_write_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write_i && !tx_rise) |=> !tx_pend_q);
endmodule

// File: rtl/uart_ii_prio.sv
module uart_ii_prio
  import uart_ii_pkg::*;
(
  input  logic [NSRC-1:0]   req_i,
  output logic [CODE_W-1:0] code_o
);
  logic [NSRC:0]   taken;
  logic [NSRC-1:0] grant;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_rank
    assign grant[i]   = req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end

  always_comb begin
    code_o = taken[NSRC] ? '0 : CODE_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) code_o = code_o | src_code(i);
    end
  end
endmodule

// File: rtl/uart_ii_hold.sv
module uart_ii_hold
  import uart_ii_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ident_rd_i,
  input  logic              fifo_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [7:0]        ident_o
);
  logic [7:0] live;
  logic [7:0] ident_d, ident_q;

  always_comb begin
    live    = {{2{fifo_en_i}}, 2'b00, code_i};
    ident_d = ident_rd_i ? ident_q : live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ident_q <= {4'h0, CODE_NONE};
    else        ident_q <= ident_d;
  end

  assign ident_o = ident_q;

  assert_frozen_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ident_rd_i |=> $stable(ident_o));
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_ii_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en_i,
  input  logic       line_err_i,
  input  logic       rx_ready_i,
  input  logic       rx_timeout_i,
  input  logic       tx_empty_i,
  input  logic       tx_write_i,
  input  logic       ie_line_i,
  input  logic       ie_rx_i,
  input  logic       ie_tx_i,
  input  logic       ident_rd_i,
  output logic [7:0] ident_o,
  output logic       irq_o
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0]   rst_sync_q;
  logic                rst_int_n;
  logic [NSRC-1:0]     req;
  logic [CODE_W-1:0]   code;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_MSB];

  uart_ii_srcq u_srcq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .fifo_en_i    (fifo_en_i),
    .line_err_i   (line_err_i),
    .rx_ready_i   (rx_ready_i),
    .rx_timeout_i (rx_timeout_i),
    .tx_empty_i   (tx_empty_i),
    .tx_write_i   (tx_write_i),
    .ie_line_i    (ie_line_i),
    .ie_rx_i      (ie_rx_i),
    .ie_tx_i      (ie_tx_i),
    .ident_rd_i   (ident_rd_i),
    .shown_code_i (ident_o[CODE_W-1:0]),
    .req_o        (req)
  );

  uart_ii_prio u_prio (
    .req_i  (req),
    .code_o (code)
  );

  uart_ii_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ident_rd_i (ident_rd_i),
    .fifo_en_i  (fifo_en_i),
    .code_i     (code),
    .ident_o    (ident_o)
  );

  assign irq_o = ~ident_o[0];

  assert_line_wins_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_err_i && ie_line_i && !ident_rd_i) |=> (ident_o[3:0] == 4'b0110));

  assert_timeout_over_rx_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_timeout_i && ie_rx_i && fifo_en_i && !ident_rd_i && !(line_err_i && ie_line_i))
      |=> (ident_o[3:0] == 4'b1100));

  assert_plain_mode_bits_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!fifo_en_i && !ident_rd_i) |=> (!ident_o[3] && ident_o[7:4] == 4'h0));
endmodule

// File: tb/uart_int_ident_bench.sv
module uart_int_ident_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en_i = 0, line_err_i = 0, rx_ready_i = 0, rx_timeout_i = 0;
  logic tx_empty_i = 0, tx_write_i = 0;
  logic ie_line_i = 0, ie_rx_i = 0, ie_tx_i = 0, ident_rd_i = 0;
  logic [7:0] ident_o;
  logic irq_o;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_int_ident u_uart_int_ident (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .line_err_i(line_err_i),
    .rx_ready_i(rx_ready_i), .rx_timeout_i(rx_timeout_i), .tx_empty_i(tx_empty_i),
    .tx_write_i(tx_write_i), .ie_line_i(ie_line_i), .ie_rx_i(ie_rx_i),
    .ie_tx_i(ie_tx_i), .ident_rd_i(ident_rd_i), .ident_o(ident_o), .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] exp);
    vectors++;
    if (ident_o !== exp || irq_o !== ~exp[0]) begin
      fails++;
      $display("FAIL %s: ident=%02h irq=%b expected ident=%02h irq=%b",
               tag, ident_o, irq_o, exp, ~exp[0]);
    end
  endtask

  function automatic logic [7:0] expect_id(input logic fifo, ls, rx, to,
                                           input logic enls, enrx, tx);
    logic [3:0] c;
    if (ls && enls)              c = 4'b0110;
    else if (fifo && to && enrx) c = 4'b1100;
    else if (rx && enrx)         c = 4'b0100;
    else if (tx)                 c = 4'b0010;
    else                         c = 4'b0001;
    return {fifo, fifo, 2'b00, c};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 reset value", 8'h01);

    ie_line_i = 1; ie_rx_i = 1; ie_tx_i = 1;
    step();
    chk("R2 idle with enables", 8'h01);

    // R7 freeze, R8 capture during read
    rx_ready_i = 1; step();
    chk("R7 follows one cycle later", 8'h04);
    ident_rd_i = 1; line_err_i = 1; step();
    chk("R7 frozen first cycle", 8'h04);
    step();
    chk("R7 frozen second cycle", 8'h04);
    fifo_en_i = 1; step();
    chk("R7 frozen across mode change", 8'h04);
    ident_rd_i = 0; step();
    chk("R8 event shown after read", 8'hC6);
    line_err_i = 0; rx_ready_i = 0; fifo_en_i = 0; step();
    chk("R2 back to idle", 8'h01);

    // R10 read that reports tx clears it
    tx_empty_i = 1; step();
    chk("R9 tx event", 8'h02);
    ident_rd_i = 1; step();
    chk("R10 tx shown during read", 8'h02);
    ident_rd_i = 0; step();
    chk("R10 tx cleared by read", 8'h01);

    // R10 read reporting another code keeps tx
    tx_empty_i = 0; step();
    tx_empty_i = 1; line_err_i = 1; step();
    chk("R3 line over tx", 8'h06);
    ident_rd_i = 1; step();
    ident_rd_i = 0; line_err_i = 0; step();
    chk("R10 tx kept after other read", 8'h02);

    // R11 write clears
    tx_write_i = 1; step(); tx_write_i = 0;
    chk("R11 write clears tx", 8'h01);
    tx_empty_i = 0; step();
    tx_empty_i = 1; tx_write_i = 1; step(); tx_write_i = 0;
    chk("R11 new event beats write", 8'h02);

    // R8/R9 event arriving mid-read survives that read
    tx_write_i = 1; tx_empty_i = 0; step(); tx_write_i = 0; step();
    chk("R11 cleared before read", 8'h01);
    ident_rd_i = 1; step();
    tx_empty_i = 1; step();
    chk("R7 frozen while tx arrives", 8'h01);
    ident_rd_i = 0; step();
    chk("R8 tx from mid-read visible", 8'h02);
    tx_write_i = 1; tx_empty_i = 0; step(); tx_write_i = 0;

    // R6 disabled tx, then enabling while empty is an event (R9)
    ie_tx_i = 0; step();
    tx_empty_i = 1; step();
    chk("R6 tx disabled", 8'h01);
    ie_tx_i = 1; step();
    chk("R9 enable while empty", 8'h02);
    tx_write_i = 1; tx_empty_i = 0; step(); tx_write_i = 0;

    // R4 time-out only in FIFO mode
    rx_timeout_i = 1; step();
    chk("R4 timeout ignored in plain mode", 8'h01);
    fifo_en_i = 1; step();
    chk("R4 R5 timeout in FIFO mode", 8'hCC);
    rx_ready_i = 1; step();
    chk("R4 timeout over rx data", 8'hCC);
    rx_timeout_i = 0; rx_ready_i = 0; fifo_en_i = 0; step();

    // Exhaustive sweep: R3 R4 R5 R6
    for (int v = 0; v < 128; v++) begin
      logic [6:0] b;
      b = v[6:0];
      ie_tx_i = 1; tx_empty_i = 0; tx_write_i = 1; step();
      tx_write_i = 0;
      tx_empty_i = b[6];
      fifo_en_i = b[0]; line_err_i = b[1]; rx_ready_i = b[2];
      rx_timeout_i = b[3]; ie_line_i = b[4]; ie_rx_i = b[5];
      step();
      chk("R3 R4 R5 R6 sweep",
          expect_id(b[0], b[1], b[2], b[3], b[4], b[5], b[6]));
    end

    finish_run();
  end
endmodule